// File: doc/BRIEF.md
# Fall-Through Strobe-Handshake FIFO

This block is a first-in first-out buffer whose words fall through to the output without a read request. The default size is 64 words of 9 bits. No read or write enable is used. A writer raises a shift-in strobe to hand over a word and lowers it to release the word. A reader raises a shift-out strobe to take the word on display and lowers it to let the next stored word advance. Two flags guide both sides. `in_rdy` means the input stage will take a word now. `out_rdy` means the output holds a valid word. The data bits carry no weighting, so a narrower user can tie off the unused input bits.

All three asynchronous controls pass through a two-flop stage on the system clock: the shift-in strobe, the shift-out strobe and the active-low reset. Two small state machines act on these controls. The input machine has the states IN_READY, IN_HOLD, IN_MOVE and IN_FULL:
- IN_READY goes to IN_HOLD when the strobe is high, and the word is captured on that transition.
- IN_HOLD goes to IN_MOVE when the strobe is low.
- IN_MOVE goes to IN_READY after `XFER_LAT` cycles if space remains, and to IN_FULL if it does not.
- IN_FULL goes to IN_READY once space appears.

The output machine has the states OUT_EMPTY, OUT_MOVE, OUT_SHOW and OUT_TAKEN:
- OUT_EMPTY goes to OUT_MOVE when a stored word is waiting.
- OUT_MOVE goes to OUT_SHOW after `XFER_LAT` cycles, and the word is loaded into the output register on that transition.
- OUT_SHOW goes to OUT_TAKEN when the strobe is high.
- OUT_TAKEN goes to OUT_MOVE when the strobe is low and a word is waiting. It goes to OUT_EMPTY when the strobe is low and nothing is waiting.

An active-low output enable gates the data port.

Top module: `ft_fifo`

## Requirements
- R1: Words leave in the order they arrived, with their values unchanged. Capacity is `DEPTH` words, and this count includes the word in the input stage and the word on the output.
- R2: While reset is asserted, and right after it is released, `in_rdy` is 1 and `out_rdy` is 0. All stored words are discarded. The output word register keeps its value.
- R3: When `in_rdy` is 1 and the synchronised `shift_in` is high, the word on `din` is captured and `in_rdy` goes to 0. The word moves on only after `shift_in` falls. `in_rdy` then returns to 1 if space remains.
- R4: While `DEPTH` words are held, `in_rdy` stays 0.
- R5: When `out_rdy` is 1 and the synchronised `shift_out` is high, the word is consumed and `out_rdy` goes to 0 on the next cycle. The next stored word advances only after `shift_out` falls.
- R6: `out_rdy` is 1 only while a valid word is on the output. After the last word is taken, `out_rdy` stays 0 and `q` keeps that last word.
- R7: If `shift_in` is held high while the buffer is full, the word loads when a slot frees. `in_rdy` shows a one-cycle high pulse and then goes low again because the buffer is full again.
- R8: If `shift_out` is held high while the buffer is empty, the arriving word makes `out_rdy` pulse high for one cycle and is consumed. No further word is shown until `shift_out` goes low.
- R9: A `shift_in` pulse that begins and ends while the buffer is full is ignored and stores nothing.
- R10: If `shift_in` is high when reset is released, `din` is captured into the input stage.
- R11: When `oe_n` is 1, `q_en` is 0 and `q` is all zeros. When `oe_n` is 0, `q_en` is 1 and `q` shows the output word.
- R12: Consider an empty buffer. `shift_in` is driven low just after a falling clock edge, and the clock keeps running. `in_rdy` returns to 1 at the (`XFER_LAT`+3)-th following falling edge: two synchroniser cycles, one decision cycle and `XFER_LAT` transfer cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| shift_in | input | 1 | Level strobe: capture when high, release when low |
| shift_out | input | 1 | Level strobe: consume when high, advance when low |
| din | input | WIDTH | Input word |
| oe_n | input | 1 | Active-low output enable |
| in_rdy | output | 1 | Input stage ready for a word |
| out_rdy | output | 1 | Output holds a valid word |
| q | output | WIDTH | Output word, zero while disabled |
| q_en | output | 1 | Output drive enable (high-impedance when 0) |

## Verification
The bench builds the block with `WIDTH`=4, `DEPTH`=4 and `XFER_LAT`=2. With these values the buffer fills in four handshakes, so the full-state cases can be reached in a few dozen cycles. These cases are the overflow pulse, the held shift-in waiting for a slot, and a reset applied with data inside. The 4-bit width lets all sixteen data values pass through the buffer in fill-and-drain groups. The short transfer latency makes the exact flag-return cycle a small number that can be checked.

// File: rtl/ft_pkg.sv
package ft_pkg;
    typedef enum logic [1:0] {
        IN_READY = 2'd0,
        IN_HOLD  = 2'd1,
        IN_MOVE  = 2'd2,
        IN_FULL  = 2'd3
    } in_state_e;

    typedef enum logic [1:0] {
        OUT_EMPTY = 2'd0,
        OUT_MOVE  = 2'd1,
        OUT_SHOW  = 2'd2,
        OUT_TAKEN = 2'd3
    } out_state_e;
endpackage

// File: rtl/ft_sync.sv
module ft_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/ft_queue.sv
module ft_queue #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign rdata = mem[rp];
endmodule

// File: rtl/ft_in_ctrl.sv
module ft_in_ctrl
    import ft_pkg::*;
#(
    parameter int XFER_LAT = 2,
    localparam int LW = (XFER_LAT > 1) ? $clog2(XFER_LAT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic si_lvl,
    input  logic space,
    output logic load,
    output logic push,
    output logic rdy
);
    in_state_e st, st_nxt;
    logic [LW-1:0] cnt;
    logic done;

    assign done = (st == IN_MOVE) && (cnt == LW'(XFER_LAT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= IN_READY;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= (st == IN_MOVE) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            IN_READY: if (si_lvl)  st_nxt = IN_HOLD;
            IN_HOLD:  if (!si_lvl) st_nxt = IN_MOVE;
            IN_MOVE:  if (done)    st_nxt = space ? IN_READY : IN_FULL;
            IN_FULL:  if (space)   st_nxt = IN_READY;
        endcase
    end

    always_comb begin
        rdy  = (st == IN_READY);
        load = (st == IN_READY) && si_lvl;
        push = done;
    end
endmodule

// File: rtl/ft_out_ctrl.sv
module ft_out_ctrl
    import ft_pkg::*;
#(
    parameter int XFER_LAT = 2,
    localparam int LW = (XFER_LAT > 1) ? $clog2(XFER_LAT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic so_lvl,
    input  logic avail,
    output logic pop,
    output logic take,
    output logic rdy
);
    out_state_e st, st_nxt;
    logic [LW-1:0] cnt;
    logic done;

    assign done = (st == OUT_MOVE) && (cnt == LW'(XFER_LAT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= OUT_EMPTY;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= (st == OUT_MOVE) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            OUT_EMPTY: if (avail)   st_nxt = OUT_MOVE;
            OUT_MOVE:  if (done)    st_nxt = OUT_SHOW;
            OUT_SHOW:  if (so_lvl)  st_nxt = OUT_TAKEN;
            OUT_TAKEN: if (!so_lvl) st_nxt = avail ? OUT_MOVE : OUT_EMPTY;
        endcase
    end

    always_comb begin
        rdy  = (st == OUT_SHOW);
        take = (st == OUT_SHOW) && so_lvl;
        pop  = done;
    end
endmodule

// File: rtl/ft_fifo.sv
module ft_fifo #(
    parameter int WIDTH    = 9,
    parameter int DEPTH    = 64,
    parameter int XFER_LAT = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic             shift_out,
    input  logic [WIDTH-1:0] din,
    input  logic             oe_n,
    output logic             in_rdy,
    output logic             out_rdy,
    output logic [WIDTH-1:0] q,
    output logic             q_en
);
    logic [1:0]       rst_q;
    logic             core_rst_n;
    logic [1:0]       strobe_s;
    logic             si_lvl, so_lvl;
    logic             load, push, pop, take;
    logic [WIDTH-1:0] in_word, dout, qdata;
    logic [CW-1:0]    qcnt, fill;

    // reset: asserts at once, releases through two flops
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_q <= 2'b00;
        else        rst_q <= {rst_q[0], 1'b1};
    end
    assign core_rst_n = rst_q[1];

    ft_sync #(.N(2)) u_sync (
        .clk(clk), .rst_n(core_rst_n),
        .d({shift_out, shift_in}), .q(strobe_s)
    );
    assign si_lvl = strobe_s[0];
    assign so_lvl = strobe_s[1];

    ft_in_ctrl #(.XFER_LAT(XFER_LAT)) u_in (
        .clk(clk), .rst_n(core_rst_n), .si_lvl(si_lvl),
        .space(fill < CW'(DEPTH)), .load(load), .push(push), .rdy(in_rdy)
    );

    ft_out_ctrl #(.XFER_LAT(XFER_LAT)) u_out (
        .clk(clk), .rst_n(core_rst_n), .so_lvl(so_lvl),
        .avail(qcnt != '0), .pop(pop), .take(take), .rdy(out_rdy)
    );

    ft_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst_n(core_rst_n), .push(push), .wdata(in_word),
        .pop(pop), .rdata(qdata), .count(qcnt)
    );

    always_ff @(posedge clk) begin
        if (load) in_word <= din;
        if (pop)  dout    <= qdata;
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) fill <= '0;
        else             fill <= fill + CW'(load) - CW'(take);
    end

    assign q_en = !oe_n;
    assign q    = oe_n ? '0 : dout;
endmodule

// File: rtl/ft_fifo_chk.sv
module ft_fifo_chk #(
    parameter int WIDTH    = 9,
    parameter int DEPTH    = 64,
    parameter int XFER_LAT = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_rst_n,
    input logic             si_lvl,
    input logic             so_lvl,
    input logic             in_rdy,
    input logic             out_rdy,
    input logic [CW-1:0]    fill,
    input logic [WIDTH-1:0] dout,
    input logic [WIDTH-1:0] q,
    input logic             q_en,
    input logic             oe_n
);
    logic [15:0] low_run;
    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n)          low_run <= '0;
        else if (in_rdy)          low_run <= '0;
        else if (low_run != '1)   low_run <= low_run + 1'b1;
    end

    assert_reset_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> (in_rdy && !out_rdy));
    assert_capture_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
        (in_rdy && si_lvl) |=> !in_rdy);
    assert_full_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
        in_rdy |-> (fill < CW'(DEPTH)));
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
        fill <= CW'(DEPTH));
    assert_take_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
        (out_rdy && so_lvl) |=> !out_rdy);
    assert_valid_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
        out_rdy |-> (fill != '0));
    assert_new_word_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
        !$stable(dout) |-> out_rdy);
    assert_oe_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
        oe_n |-> (!q_en && q == '0));
    assert_move_time_R12: assert property (@(posedge clk) disable iff (!core_rst_n)
        $rose(in_rdy) |-> (low_run >= 16'(XFER_LAT)));
endmodule

bind ft_fifo ft_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .XFER_LAT(XFER_LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n), .si_lvl(si_lvl),
    .so_lvl(so_lvl), .in_rdy(in_rdy), .out_rdy(out_rdy), .fill(fill),
    .dout(dout), .q(q), .q_en(q_en), .oe_n(oe_n)
);

// File: tb/tb_ft_fifo.sv
module tb_ft_fifo;
    localparam int W = 4;
    localparam int D = 4;
    localparam int L = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_in = 1'b0, shift_out = 1'b0, oe_n = 1'b0;
    logic [W-1:0] din = '0;
    logic in_rdy, out_rdy, q_en;
    logic [W-1:0] q;

    int total = 0, failed = 0, cyc = 0;
    int dir_rises = 0, dor_rises = 0;
    logic dir_prev = 1'b0, dor_prev = 1'b0;

    always #2.5 clk = ~clk;

    ft_fifo #(.WIDTH(W), .DEPTH(D), .XFER_LAT(L)) dut (
        .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .shift_out(shift_out),
        .din(din), .oe_n(oe_n), .in_rdy(in_rdy), .out_rdy(out_rdy),
        .q(q), .q_en(q_en)
    );

    always @(negedge clk) begin
        if (in_rdy && !dir_prev) dir_rises++;
        if (out_rdy && !dor_prev) dor_rises++;
        dir_prev <= in_rdy;
        dor_prev <= out_rdy;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; failed++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    function automatic logic [W-1:0] wv(input int k);
        return W'(k * 5 + 3);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_dir(input logic v, input string req);
        int n = 0;
        while (in_rdy !== v && n < 200) begin @(negedge clk); n++; end
        if (in_rdy !== v) chk(1'b0, req, int'(in_rdy), int'(v));
    endtask

    task automatic wait_dor(input logic v, input string req);
        int n = 0;
        while (out_rdy !== v && n < 200) begin @(negedge clk); n++; end
        if (out_rdy !== v) chk(1'b0, req, int'(out_rdy), int'(v));
    endtask

    task automatic push(input logic [W-1:0] w);
        wait_dir(1'b1, "R3 ready");
        din = w; shift_in = 1'b1;
        wait_dir(1'b0, "R3 busy");
        shift_in = 1'b0;
    endtask

    task automatic pop_chk(input logic [W-1:0] exp, input string req);
        wait_dor(1'b1, req);
        chk(q == exp, req, int'(q), int'(exp));
        shift_out = 1'b1;
        wait_dor(1'b0, "R5 taken");
        shift_out = 1'b0;
    endtask

    initial begin
        int n;
        // reset
        idle(4);
        chk(in_rdy == 1'b1 && out_rdy == 1'b0, "R2 flags in reset", {in_rdy, out_rdy}, 2);
        rst_n = 1'b1;
        idle(6);
        chk(in_rdy == 1'b1 && out_rdy == 1'b0, "R2 flags after reset", {in_rdy, out_rdy}, 2);

        // exact return time of in_rdy on an empty buffer
        wait_dir(1'b1, "R12 ready");
        din = wv(0); shift_in = 1'b1;
        wait_dir(1'b0, "R3 busy");
        shift_in = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!in_rdy && n < 50);
        chk(n == L + 3, "R12 transfer latency", n, L + 3);

        // fill to capacity
        for (int k = 1; k < D; k++) push(wv(k));
        idle(20);
        chk(in_rdy == 1'b0, "R4 full flag", int'(in_rdy), 0);
        chk(out_rdy == 1'b1, "R6 valid word shown", int'(out_rdy), 1);

        // overflow pulse while full
        din = 4'hF; shift_in = 1'b1; idle(10); shift_in = 1'b0; idle(20);
        chk(in_rdy == 1'b0, "R9 still full after pulse", int'(in_rdy), 0);
        for (int k = 0; k < D; k++) pop_chk(wv(k), "R1 R9 order");
        idle(20);
        chk(out_rdy == 1'b0, "R6 empty after last", int'(out_rdy), 0);
        chk(q == wv(D - 1), "R6 last word kept", int'(q), int'(wv(D - 1)));

        // shift_out held high while empty
        shift_out = 1'b1; idle(10);
        dor_rises = 0;
        push(wv(7));
        n = 0;
        while (!out_rdy && n < 50) begin @(negedge clk); n++; end
        chk(q == wv(7), "R8 word on pulse", int'(q), int'(wv(7)));
        push(wv(8));
        idle(30);
        chk(dor_rises == 1, "R8 single pulse", dor_rises, 1);
        chk(out_rdy == 1'b0 && q == wv(7), "R8 held until release", int'(q), int'(wv(7)));
        shift_out = 1'b0;
        pop_chk(wv(8), "R5 advance after release");

        // shift_in held high while full
        for (int k = 10; k < 10 + D; k++) push(wv(k));
        idle(10);
        din = wv(20); shift_in = 1'b1; idle(20);
        chk(in_rdy == 1'b0, "R7 waiting while full", int'(in_rdy), 0);
        dir_rises = 0;
        pop_chk(wv(10), "R1 head");
        idle(20);
        chk(dir_rises == 1 && in_rdy == 1'b0, "R7 one ready pulse", dir_rises, 1);
        shift_in = 1'b0; idle(20);
        chk(in_rdy == 1'b0 && dir_rises == 1, "R7 full again", int'(in_rdy), 0);
        for (int k = 11; k < 10 + D; k++) pop_chk(wv(k), "R1 order");
        pop_chk(wv(20), "R7 pending word");

        // reset with data inside and shift_in high
        push(wv(30)); push(wv(31));
        wait_dor(1'b1, "R2 setup");
        din = wv(33); shift_in = 1'b1; rst_n = 1'b0;
        idle(3);
        chk(in_rdy == 1'b1 && out_rdy == 1'b0, "R2 flags on reset", {in_rdy, out_rdy}, 2);
        chk(q == wv(30), "R2 output word kept", int'(q), int'(wv(30)));
        rst_n = 1'b1; idle(15);
        chk(in_rdy == 1'b0, "R10 captured at release", int'(in_rdy), 0);
        shift_in = 1'b0;
        pop_chk(wv(33), "R10 word loaded");
        idle(20);
        chk(out_rdy == 1'b0, "R2 contents cleared", int'(out_rdy), 0);

        // output enable
        oe_n = 1'b1; idle(1);
        chk(q_en == 1'b0 && q == '0, "R11 disabled", int'(q), 0);
        oe_n = 1'b0; idle(1);
        chk(q_en == 1'b1 && q == wv(33), "R11 enabled", int'(q), int'(wv(33)));

        // every data value, in fill-and-drain groups
        for (int g = 0; g < (1 << W); g += D) begin
            for (int k = 0; k < D; k++) push(W'(g + k));
            for (int k = 0; k < D; k++) pop_chk(W'(g + k), "R1 value sweep");
        end

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule